// File: doc/BRIEF.md
# Interlaced Video Timing Generator

This block produces the per-pixel timing strobes for an interlaced digital video stream. A pixel counter and a line counter, together with a field toggle, walk through the raster. From their state the block decodes six outputs: horizontal sync, vertical sync, a horizontal active window, a vertical active window, a field flag, and a flag that marks the blue-difference chroma sample of each 4:2:2 pixel pair. All six outputs come from registers, so they carry no decode glitches.

The two fields are built differently. The odd field has `LINES_ODD` lines and the even field has `LINES_EVEN` lines. Vertical sync lasts `VS_LINES` lines in both fields. In the odd field its edges fall at the first pixel of a line. In the even field they fall half a line later. A six-bit configuration word sets the polarity of each of the four sync and active outputs. The same word enables two gating options: the horizontal window can be ANDed with the vertical window, and the vertical window can be ANDed with the horizontal window. The word is loaded through a synchronous write port with an address compare.

Top module: `vtg_top`

## Requirements
- R1: While `rst` is high, the outputs read `hsync_o`=1, `vsync_o`=1, `hact_o`=0, `vact_o`=0, `field_o`=0 and `blue_o`=0. Every configuration bit clears to 0.
- R2: The pixel index counts 0..`H_TOTAL`-1 on every line. Horizontal sync is asserted at pixel indices `HS_START` through `HS_START`+`HS_WIDTH`-1, all of which lie in the blanking part. The horizontal window is asserted at the last `H_ACTIVE` pixel indices. Each output shows the decode of the counter state from one clock earlier.
- R3: An odd field of `LINES_ODD` lines is followed by an even field of `LINES_EVEN` lines, and the pair then repeats. `field_o` is 0 in the odd field and 1 in the even field.
- R4: Vertical sync is asserted for `VS_LINES` lines starting at line 0. In the odd field it rises and falls at pixel 0, where horizontal sync and the horizontal window are both inactive.
- R5: In the even field, vertical sync rises and falls at pixel `H_TOTAL`/2, which lies inside the horizontal window.
- R6: The vertical window covers the whole of lines `VACT_FIRST` through `VACT_FIRST`+`VACT_LINES`-1 in both fields.
- R7: Configuration bit 4 (hact_gate) set to 1 makes the horizontal window equal to horizontal AND vertical. Set to 0, the horizontal window appears on every line.
- R8: Configuration bit 5 (vact_gate) set to 1 makes the vertical window equal to vertical AND horizontal. Set to 0, the vertical window covers whole lines.
- R9: The polarity bits are: bit 0 (1 = horizontal sync active high), bit 1 (1 = vertical sync active high), bit 2 (1 = horizontal window active low), bit 3 (1 = vertical window active low).
- R10: `blue_o` is 1 only on pixels that are inside both windows and that sit at an even offset (0, 2, 4, ...) from the first active pixel. It is never high on two cycles in a row.
- R11: A write with `cfg_we`=1 and `cfg_addr`=`CFG_ADDR` loads `cfg_wdata[5:0]` at that clock edge. The outputs use the new value from the following edge. A write to any other address is ignored, and so are bits above 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | DATA_W | Configuration write data |
| hsync_o | output | 1 | Horizontal sync, programmable polarity |
| vsync_o | output | 1 | Vertical sync, programmable polarity |
| hact_o | output | 1 | Horizontal active window, programmable polarity |
| vact_o | output | 1 | Vertical active window, programmable polarity |
| field_o | output | 1 | Field flag, 0 odd, 1 even |
| blue_o | output | 1 | Blue-difference chroma sample marker |

## Verification
A configuration write can land on the same clock edge that raster decoding uses to produce an output transition, for example a vertical sync edge or a window edge. If the timing is wrong, the new polarity or gating shows up one cycle early or late. The bench places random writes throughout several fields, mixing writes to the real address with writes to other addresses. Every cycle it compares all six outputs with a model that applies the old configuration on the write edge and the new configuration from the next edge onward. Over several fields, writes land on sync and window edges as well as mid-line.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int CFG_BITS = 6;

   typedef struct packed {
      logic vact_gate;
      logic hact_gate;
      logic vact_inv;
      logic hact_inv;
      logic vs_hi;
      logic hs_hi;
   } vtg_cfg_t;

   localparam vtg_cfg_t CFG_RESET = '0;
endpackage

// File: rtl/vtg_cfg_regs.sv
module vtg_cfg_regs
   import vtg_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int CFG_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output vtg_cfg_t          cfg
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_ADDR);

   generate
      if (DATA_W < CFG_BITS) begin : g_bad_dw
         $error("vtg_cfg_regs: DATA_W narrower than configuration word");
      end
      if (CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("vtg_cfg_regs: CFG_ADDR outside address space");
      end
   endgenerate

   logic hit;
   assign hit = we && (addr == MY_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg <= CFG_RESET;
      end else if (hit) begin
         cfg <= vtg_cfg_t'(wdata[CFG_BITS-1:0]);
      end
   end

   assert_cfg_ignore_R11: assert property (@(posedge clk) disable iff (rst)
      !hit |=> $stable(cfg));
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter #(
   parameter int H_TOTAL    = 858,
   parameter int LINES_ODD  = 263,
   parameter int LINES_EVEN = 262,
   parameter int PX_W       = 10,
   parameter int LN_W       = 9
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PX_W-1:0] px,
   output logic [LN_W-1:0] ln,
   output logic            fld
);
   localparam logic [PX_W-1:0] PX_LAST  = PX_W'(H_TOTAL - 1);
   localparam logic [LN_W-1:0] ODD_LAST = LN_W'(LINES_ODD - 1);
   localparam logic [LN_W-1:0] EVN_LAST = LN_W'(LINES_EVEN - 1);

   logic [LN_W-1:0] ln_last;
   assign ln_last = fld ? EVN_LAST : ODD_LAST;

   always_ff @(posedge clk) begin
      if (rst) begin
         px  <= '0;
         ln  <= '0;
         fld <= 1'b0;
      end else if (px == PX_LAST) begin
         px <= '0;
         if (ln == ln_last) begin
            ln  <= '0;
            fld <= ~fld;
         end else begin
            ln <= ln + 1'b1;
         end
      end else begin
         px <= px + 1'b1;
      end
   end

   assert_px_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (px == PX_LAST) |=> (px == '0));

   assert_field_flip_R3: assert property (@(posedge clk) disable iff (rst)
      (px == PX_LAST && ln == ln_last) |=> (ln == '0 && fld != $past(fld)));
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
   parameter int H_TOTAL    = 858,
   parameter int H_ACTIVE   = 720,
   parameter int HS_START   = 16,
   parameter int HS_WIDTH   = 62,
   parameter int VS_LINES   = 3,
   parameter int VACT_FIRST = 20,
   parameter int VACT_LINES = 240,
   parameter int PX_W       = 10,
   parameter int LN_W       = 9
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PX_W-1:0] px,
   input  logic [LN_W-1:0] ln,
   input  logic            fld,
   output logic            hs_raw,
   output logic            vs_raw,
   output logic            hact_raw,
   output logic            vact_raw,
   output logic            blue_raw
);
   localparam int              H_BLANK  = H_TOTAL - H_ACTIVE;
   localparam logic [PX_W-1:0] HB_PX    = PX_W'(H_BLANK);
   localparam logic [PX_W-1:0] HS_FIRST = PX_W'(HS_START);
   localparam logic [PX_W-1:0] HS_END   = PX_W'(HS_START + HS_WIDTH);
   localparam logic [PX_W-1:0] MID_PX   = PX_W'(H_TOTAL / 2);
   localparam logic [LN_W-1:0] VS_END   = LN_W'(VS_LINES);
   localparam logic [LN_W-1:0] VA_FIRST = LN_W'(VACT_FIRST);
   localparam logic [LN_W-1:0] VA_END   = LN_W'(VACT_FIRST + VACT_LINES);
   localparam logic            HB_PAR   = HB_PX[0];

   logic vs_odd, vs_even;

   always_comb begin
      hs_raw   = (px >= HS_FIRST) && (px < HS_END);
      hact_raw = (px >= HB_PX);
      vact_raw = (ln >= VA_FIRST) && (ln < VA_END);
      vs_odd   = (ln < VS_END);
      vs_even  = ((ln > '0) && (ln < VS_END)) ||
                 ((ln == '0) && (px >= MID_PX)) ||
                 ((ln == VS_END) && (px < MID_PX));
      vs_raw   = fld ? vs_even : vs_odd;
      blue_raw = hact_raw && vact_raw && (px[0] == HB_PAR);
   end

   assert_hs_in_blank_R2: assert property (@(posedge clk) disable iff (rst)
      hs_raw |-> !hact_raw);

   assert_vs_odd_edge_R4: assert property (@(posedge clk) disable iff (rst)
      (!fld && vs_raw != $past(vs_raw) && $past(fld) == fld) |-> (px == '0 && !hs_raw && !hact_raw));

   assert_vs_even_edge_R5: assert property (@(posedge clk) disable iff (rst)
      (fld && vs_raw != $past(vs_raw) && $past(fld) == fld) |-> (px == MID_PX && hact_raw));
endmodule

// File: rtl/vtg_top.sv
module vtg_top
   import vtg_pkg::*;
#(
   parameter int H_TOTAL    = 858,
   parameter int H_ACTIVE   = 720,
   parameter int HS_START   = 16,
   parameter int HS_WIDTH   = 62,
   parameter int LINES_ODD  = 263,
   parameter int LINES_EVEN = 262,
   parameter int VS_LINES   = 3,
   parameter int VACT_FIRST = 20,
   parameter int VACT_LINES = 240,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int CFG_ADDR   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              hact_o,
   output logic              vact_o,
   output logic              field_o,
   output logic              blue_o
);
   localparam int MAX_LINES = (LINES_ODD > LINES_EVEN) ? LINES_ODD : LINES_EVEN;
   localparam int PX_W      = $clog2(H_TOTAL);
   localparam int LN_W      = $clog2(MAX_LINES + 1);
   localparam int H_BLANK   = H_TOTAL - H_ACTIVE;
   localparam int N_POL     = 4;
   localparam logic [N_POL-1:0] POL_RST = 4'b0011;

   generate
      if (H_ACTIVE <= 0 || H_ACTIVE >= H_TOTAL) begin : g_bad_hact
         $error("vtg_top: H_ACTIVE must lie inside the line");
      end
      if ((H_ACTIVE % 2) != 0) begin : g_bad_pair
         $error("vtg_top: H_ACTIVE must be even for 4:2:2 pairing");
      end
      if (HS_START < 1 || HS_WIDTH < 1 || HS_START + HS_WIDTH > H_BLANK) begin : g_bad_hs
         $error("vtg_top: horizontal sync must sit inside blanking after pixel 0");
      end
      if (H_TOTAL / 2 < H_BLANK) begin : g_bad_mid
         $error("vtg_top: mid-line point must fall in the active part");
      end
      if (VS_LINES < 1 || VS_LINES >= VACT_FIRST) begin : g_bad_vs
         $error("vtg_top: vertical sync must end before the active lines");
      end
      if (VACT_FIRST + VACT_LINES > LINES_EVEN || VACT_FIRST + VACT_LINES > LINES_ODD) begin : g_bad_va
         $error("vtg_top: active lines exceed field length");
      end
   endgenerate

   vtg_cfg_t        cfg;
   logic [PX_W-1:0] px;
   logic [LN_W-1:0] ln;
   logic            fld;
   logic            hs_raw, vs_raw, hact_raw, vact_raw, blue_raw;
   logic            hact_g, vact_g;
   logic [N_POL-1:0] lvec, inv, pol_q;

   vtg_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)
   ) u_cfg (
      .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .cfg(cfg)
   );

   vtg_counter #(
      .H_TOTAL(H_TOTAL), .LINES_ODD(LINES_ODD), .LINES_EVEN(LINES_EVEN),
      .PX_W(PX_W), .LN_W(LN_W)
   ) u_cnt (
      .clk(clk), .rst(rst), .px(px), .ln(ln), .fld(fld)
   );

   vtg_decode #(
      .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .HS_START(HS_START), .HS_WIDTH(HS_WIDTH),
      .VS_LINES(VS_LINES), .VACT_FIRST(VACT_FIRST), .VACT_LINES(VACT_LINES),
      .PX_W(PX_W), .LN_W(LN_W)
   ) u_dec (
      .clk(clk), .rst(rst), .px(px), .ln(ln), .fld(fld),
      .hs_raw(hs_raw), .vs_raw(vs_raw), .hact_raw(hact_raw),
      .vact_raw(vact_raw), .blue_raw(blue_raw)
   );

   always_comb begin
      hact_g = cfg.hact_gate ? (hact_raw && vact_raw) : hact_raw;
      vact_g = cfg.vact_gate ? (vact_raw && hact_raw) : vact_raw;
      lvec   = {vact_g, hact_g, vs_raw, hs_raw};
      inv    = {cfg.vact_inv, cfg.hact_inv, ~cfg.vs_hi, ~cfg.hs_hi};
   end

   for (genvar gi = 0; gi < N_POL; gi++) begin : g_pol
      always_ff @(posedge clk) begin
         if (rst) pol_q[gi] <= POL_RST[gi];
         else     pol_q[gi] <= lvec[gi] ^ inv[gi];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         field_o <= 1'b0;
         blue_o  <= 1'b0;
      end else begin
         field_o <= fld;
         blue_o  <= blue_raw;
      end
   end

   assign hsync_o = pol_q[0];
   assign vsync_o = pol_q[1];
   assign hact_o  = pol_q[2];
   assign vact_o  = pol_q[3];

   assert_blue_alternate_R10: assert property (@(posedge clk) disable iff (rst)
      blue_o |=> !blue_o);

   assert_field_steady_R3: assert property (@(posedge clk) disable iff (rst)
      (field_o != $past(field_o)) |-> ($past(px) == '0 && $past(ln) == '0));
endmodule

// File: tb/vtg_top_tb.sv
module vtg_top_tb;
   localparam int HT   = 40;
   localparam int HA   = 24;
   localparam int HB   = HT - HA;
   localparam int HSS  = 2;
   localparam int HSW  = 8;
   localparam int LO   = 13;
   localparam int LE   = 12;
   localparam int VSL  = 3;
   localparam int VAF  = 5;
   localparam int VAL  = 6;
   localparam int AW   = 4;
   localparam int CADR = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [7:0]    cfg_wdata = '0;
   logic hsync_o, vsync_o, hact_o, vact_o, field_o, blue_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   vtg_top #(
      .H_TOTAL(HT), .H_ACTIVE(HA), .HS_START(HSS), .HS_WIDTH(HSW),
      .LINES_ODD(LO), .LINES_EVEN(LE), .VS_LINES(VSL),
      .VACT_FIRST(VAF), .VACT_LINES(VAL),
      .ADDR_W(AW), .DATA_W(8), .CFG_ADDR(CADR)
   ) u_dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .hact_o(hact_o), .vact_o(vact_o),
      .field_o(field_o), .blue_o(blue_o)
   );

   // returns {blue, field, vact, hact, vs, hs} for raster position p under config c
   function automatic logic [5:0] model(input int p, input logic [5:0] c);
      int  px, lf, ln, mid;
      bit  fld, hs, vs, ha, va, hg, vg, bl;
      px  = p % HT;
      lf  = (p / HT) % (LO + LE);
      fld = (lf >= LO);
      ln  = fld ? lf - LO : lf;
      mid = HT / 2;
      hs  = (px >= HSS) && (px < HSS + HSW);
      ha  = (px >= HB);
      va  = (ln >= VAF) && (ln < VAF + VAL);
      if (!fld) vs = (ln < VSL);
      else      vs = (ln * HT + px >= mid) && (ln * HT + px < VSL * HT + mid);
      bl  = ha && va && (((px - HB) % 2) == 0);
      hg  = c[4] ? (ha && va) : ha;
      vg  = c[5] ? (va && ha) : va;
      return {bl, fld, vg ^ c[3], hg ^ c[2], c[1] ? vs : !vs, c[0] ? hs : !hs};
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp, input int p);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s pos=%0d actual=%b expected=%b", tag, p, act, exp);
      end
   endtask

   task automatic chk_all(input int p, input logic [5:0] c);
      logic [5:0] e;
      bit fld;
      e   = model(p, c);
      fld = e[4];
      chk("R2 R9 R11 hsync", hsync_o, e[0], p);
      chk(fld ? "R5 R9 vsync" : "R4 R9 vsync", vsync_o, e[1], p);
      chk("R7 R9 hact", hact_o, e[2], p);
      chk("R6 R8 vact", vact_o, e[3], p);
      chk("R3 field", field_o, e[4], p);
      chk("R10 blue", blue_o, e[5], p);
   endtask

   initial begin : main
      logic [5:0] cfg_reg, cfg_used;
      int edges;
      void'($urandom(32'd4711));
      cfg_reg = '0;
      edges   = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset levels
      chk("R1 hsync reset", hsync_o, 1'b1, -1);
      chk("R1 vsync reset", vsync_o, 1'b1, -1);
      chk("R1 hact reset", hact_o, 1'b0, -1);
      chk("R1 vact reset", vact_o, 1'b0, -1);
      chk("R1 field reset", field_o, 1'b0, -1);
      chk("R1 blue reset", blue_o, 1'b0, -1);
      rst = 1'b0;
      for (int i = 0; i < 5200; i++) begin
         @(posedge clk);
         edges++;
         cfg_used = cfg_reg;
         if (cfg_we && cfg_addr == AW'(CADR)) cfg_reg = cfg_wdata[5:0];
         @(negedge clk);
         chk_all(edges - 1, cfg_used);
         cfg_we = 1'b0;
         if (i == 500) begin
            // R11: write to a foreign address must leave the defaults in place
            cfg_we = 1'b1; cfg_addr = AW'(CADR + 1); cfg_wdata = 8'hFF;
         end else if (i == 1100) begin
            // R7 R8: both gates, default polarity
            cfg_we = 1'b1; cfg_addr = AW'(CADR); cfg_wdata = 8'hF0;
         end else if (i == 2200) begin
            // R9: all polarities inverted, no gating
            cfg_we = 1'b1; cfg_addr = AW'(CADR); cfg_wdata = 8'h0F;
         end else if (i > 3200 && ($urandom % 30) == 0) begin
            cfg_we    = 1'b1;
            cfg_addr  = (($urandom % 4) == 0) ? AW'($urandom) : AW'(CADR);
            cfg_wdata = 8'($urandom);
         end
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule